// File: doc/BRIEF.md
# Second-Order Recursive Filter Section

This block is one second-order recursive (biquad) section for signed 32-bit Q1.31 audio samples. A sample enters on a valid/ready input stream. The section keeps its last two inputs and last two outputs. It forms five coefficient products on one shared multiplier, one product per clock, and sums them into a signed 64-bit accumulator. The result goes out on a valid/ready output stream. The feedback coefficients are kept already negated, so all five terms are simply added.

Each sample is fully handled before the next one is taken. In idle the section raises `in_ready`. Accepting a sample drops `in_ready`, and it stays low through the five multiply cycles and for as long as the result waits on `out_valid`. A new sample is taken only after the consumer has accepted the result with `out_ready`. Back-pressure on the output therefore stalls the input directly. There is no buffering at either edge.

The five coefficients are plain registers, written through a select/data/write-enable port. A write lands only while the section is idle. A synchronous clear empties the history and abandons any sample in flight.

Top module: `biquad_section`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, and the four history values and five coefficients are zero.
- R2: The result is `{acc[62:32], 1'b0}`, where `acc` is the signed 64-bit sum b0·x[n] + b1·x[n−1] + b2·x[n−2] + a1·y[n−1] + a2·y[n−2]. All operands are signed two's-complement, and the feedback coefficients a1 and a2 are added, never subtracted.
- R3: When the output handshake completes (`out_valid` and `out_ready` both high), x[n−1] moves to x[n−2], the accepted input moves to x[n−1], y[n−1] moves to y[n−2], and the emitted result becomes y[n−1].
- R4: `in_ready` is low from the clock edge that accepts a sample until the edge that completes its output handshake. An `in_valid` asserted in that window is not taken.
- R5: `out_valid` rises on the fifth rising edge after the edge that accepts the input. There is one multiply-accumulate step per clock.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R7: A coefficient write with `coef_sel` 0, 1, 2, 3 or 4 loads b0, b1, b2, a1 or a2 respectively. A write with `coef_sel` 5, 6 or 7 changes no coefficient.
- R8: A coefficient write while `in_ready` is low is ignored, including a write during the multiply steps.
- R9: `clr` high at a rising edge sets all four history values to zero, discards any sample in progress, and returns the section to idle.
- R10: Accumulation and the final shift wrap modulo 2^64 and 2^32 respectively, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of history and sequencing |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 3 | Coefficient select: 0 b0, 1 b1, 2 b2, 3 a1, 4 a2 |
| coef_wdata | input | 32 | Coefficient value, Q1.31 |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Section can take a sample |
| in_data | input | 32 | Input sample, Q1.31 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Result sample, Q1.31 |

## Verification
The hardest condition to reach from the ports is a coefficient write or a clear that arrives while the five products are still being summed. The write test fires a new b0 on the cycle right after acceptance, which is before the b0 product has been formed. The clear test drops `clr` two cycles into the multiply steps. In both cases the bench then compares the outputs against a reference that still holds the old coefficients, or that holds a history emptied by the clear. Wrap-around is reached by loading the full negative value into all three feed-forward taps and repeating the full negative sample, so that the positive products sum past 2^63.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  localparam int unsigned NUM_TAPS = 5;
  localparam int unsigned SEL_W    = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAC  = 2'd1,
    ST_OUT  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/biquad_coef_regs.sv
module biquad_coef_regs #(
  parameter int unsigned W     = 32,
  parameter int unsigned NTAP  = biquad_pkg::NUM_TAPS,
  parameter int unsigned SEL_W = biquad_pkg::SEL_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [W-1:0]              wr_data,
  output logic [NTAP-1:0][W-1:0]    coefs
);
  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        coefs[t] <= '0;
      else if (wr_en && (wr_sel == SEL_W'(t)))
        coefs[t] <= wr_data;
    end
  end
endmodule

// File: rtl/biquad_ctrl.sv
module biquad_ctrl
  import biquad_pkg::*;
#(
  parameter int unsigned NTAP = NUM_TAPS,
  localparam int unsigned STEP_W = $clog2(NTAP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic              take_in,
  output logic              mac_en,
  output logic              shift_en,
  output logic [STEP_W-1:0] step
);
  seq_state_t state;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_OUT);
  assign take_in   = in_ready && in_valid && !clr;
  assign mac_en    = (state == ST_MAC) && !clr;
  assign shift_en  = out_valid && out_ready && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= '0;
    end else if (clr) begin
      state <= ST_IDLE;
      step  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (in_valid) begin
          state <= ST_MAC;
          step  <= '0;
        end
        ST_MAC: begin
          if (step == STEP_W'(NTAP-1)) state <= ST_OUT;
          else                         step  <= step + 1'b1;
        end
        ST_OUT: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_ready_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);
  p_hold_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=> out_valid);
  p_step_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MAC) |-> (step < STEP_W'(NTAP)));
  p_out_after_mac_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(state == ST_MAC && step == STEP_W'(NTAP-1)));
  p_clear_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (in_ready && !out_valid));
endmodule

// File: rtl/biquad_datapath.sv
module biquad_datapath #(
  parameter int unsigned W    = 32,
  parameter int unsigned NTAP = biquad_pkg::NUM_TAPS,
  localparam int unsigned AW     = 2 * W,
  localparam int unsigned STEP_W = $clog2(NTAP)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   take_in,
  input  logic [W-1:0]           in_data,
  input  logic                   mac_en,
  input  logic                   shift_en,
  input  logic [STEP_W-1:0]      step,
  input  logic [NTAP-1:0][W-1:0] coefs,
  output logic [W-1:0]           out_data
);
  logic [W-1:0]         x_cur, x_d1, x_d2, y_d1, y_d2;
  logic signed [AW-1:0] acc;
  logic signed [W-1:0]  mul_a, mul_b;
  logic signed [AW-1:0] prod;

  always_comb begin
    mul_a = $signed(coefs[step]);
    unique case (step)
      STEP_W'(0): mul_b = $signed(x_cur);
      STEP_W'(1): mul_b = $signed(x_d1);
      STEP_W'(2): mul_b = $signed(x_d2);
      STEP_W'(3): mul_b = $signed(y_d1);
      default:    mul_b = $signed(y_d2);
    endcase
  end

  assign prod     = AW'(mul_a) * AW'(mul_b);
  assign out_data = {acc[AW-2:W], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_cur <= '0;
      acc   <= '0;
    end else if (take_in) begin
      x_cur <= in_data;
      acc   <= '0;
    end else if (mac_en) begin
      acc <= acc + prod;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_d1 <= '0; x_d2 <= '0; y_d1 <= '0; y_d2 <= '0;
    end else if (clr) begin
      x_d1 <= '0; x_d2 <= '0; y_d1 <= '0; y_d2 <= '0;
    end else if (shift_en) begin
      x_d2 <= x_d1;
      x_d1 <= x_cur;
      y_d2 <= y_d1;
      y_d1 <= out_data;
    end
  end

  p_clear_hist_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (x_d1 == '0 && x_d2 == '0 && y_d1 == '0 && y_d2 == '0));
  p_shift_hist_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr) |=> (x_d2 == $past(x_d1) && y_d2 == $past(y_d1)
                            && y_d1 == $past(out_data) && x_d1 == $past(x_cur)));
  p_hist_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !clr) |=> ($stable(x_d1) && $stable(y_d1)));
endmodule

// File: rtl/biquad_section.sv
module biquad_section
  import biquad_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               coef_we,
  input  logic [SEL_W-1:0]   coef_sel,
  input  logic [W-1:0]       coef_wdata,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [W-1:0]       in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [W-1:0]       out_data
);
  localparam int unsigned STEP_W = $clog2(NUM_TAPS);

  logic [NUM_TAPS-1:0][W-1:0] coefs;
  logic                       take_in, mac_en, shift_en, coef_wr;
  logic [STEP_W-1:0]          step;

  assign coef_wr = coef_we && in_ready;

  biquad_coef_regs #(.W(W), .NTAP(NUM_TAPS), .SEL_W(SEL_W)) u_coefs (
    .clk(clk), .rst_n(rst_n), .wr_en(coef_wr), .wr_sel(coef_sel),
    .wr_data(coef_wdata), .coefs(coefs)
  );

  biquad_ctrl #(.NTAP(NUM_TAPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .out_ready(out_ready), .in_ready(in_ready), .out_valid(out_valid),
    .take_in(take_in), .mac_en(mac_en), .shift_en(shift_en), .step(step)
  );

  biquad_datapath #(.W(W), .NTAP(NUM_TAPS)) u_dp (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take_in(take_in),
    .in_data(in_data), .mac_en(mac_en), .shift_en(shift_en), .step(step),
    .coefs(coefs), .out_data(out_data)
  );

  p_coef_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(coefs));
  p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=> $stable(out_data));
endmodule

// File: tb/biquad_section_tb.sv
module biquad_section_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        coef_we = 1'b0;
  logic [2:0]  coef_sel = '0;
  logic [31:0] coef_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] m_c [5];
  logic [31:0] m_x1, m_x2, m_y1, m_y2;

  localparam logic [31:0] STIM [10] = '{
    32'h4000_0000, 32'h0000_0000, 32'hC000_0000, 32'h1234_5678,
    32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0001, 32'hFFFF_FFFF,
    32'h2000_0000, 32'hE000_0000
  };

  always #4 clk = ~clk;

  biquad_section u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .coef_we(coef_we),
    .coef_sel(coef_sel), .coef_wdata(coef_wdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_y(input logic [31:0] x);
    logic signed [63:0] acc;
    acc = 64'($signed(m_c[0])) * 64'($signed(x))
        + 64'($signed(m_c[1])) * 64'($signed(m_x1))
        + 64'($signed(m_c[2])) * 64'($signed(m_x2))
        + 64'($signed(m_c[3])) * 64'($signed(m_y1))
        + 64'($signed(m_c[4])) * 64'($signed(m_y2));
    return {acc[62:32], 1'b0};
  endfunction

  task automatic model_shift(input logic [31:0] x, input logic [31:0] y);
    m_x2 = m_x1; m_x1 = x; m_y2 = m_y1; m_y1 = y;
  endtask

  task automatic model_clear();
    m_x1 = '0; m_x2 = '0; m_y1 = '0; m_y2 = '0;
  endtask

  task automatic write_coef(input logic [2:0] sel, input logic [31:0] val);
    @(negedge clk);
    coef_we = 1'b1; coef_sel = sel; coef_wdata = val;
    @(negedge clk);
    coef_we = 1'b0;
    if (sel < 3'd5) m_c[sel] = val;
  endtask

  // Accept a sample; returns at the negedge right after the accepting edge.
  task automatic push(input logic [31:0] x);
    @(negedge clk);
    in_valid = 1'b1; in_data = x;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_out(output int lat);
    lat = 0;
    while (!out_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic take_out();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_sample(input logic [31:0] x, input string req, input int hold);
    logic [31:0] exp;
    int lat;
    exp = model_y(x);
    push(x);
    chk(in_ready == 1'b0, "R4 busy after accept", 32'(in_ready), 32'd0);
    wait_out(lat);
    chk(lat == 5, "R5 latency", 32'(lat), 32'd5);
    chk(out_data == exp, req, out_data, exp);
    for (int h = 0; h < hold; h++) begin
      in_valid = 1'b1; in_data = 32'hDEAD_BEEF;
      @(negedge clk);
      chk(out_valid && out_data == exp, "R6 held output", out_data, exp);
      chk(in_ready == 1'b0, "R4 no input while pending", 32'(in_ready), 32'd0);
    end
    in_valid = 1'b0;
    take_out();
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R4 idle after handshake",
        {30'd0, in_ready, out_valid}, 32'd2);
    model_shift(x, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] exp;
    int lat;
    for (int i = 0; i < 5; i++) m_c[i] = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset handshake",
        {30'd0, in_ready, out_valid}, 32'd2);
    // R1: zero coefficients and history give zero output
    run_sample(32'h7FFF_FFFF, "R1 zero coefs output", 0);

    write_coef(3'd0, 32'h2000_0000);
    write_coef(3'd1, 32'h4000_0000);
    write_coef(3'd2, 32'h2000_0000);
    write_coef(3'd3, 32'h2666_6666);
    write_coef(3'd4, 32'hF000_0000);
    // R7: unused selects must not touch any coefficient
    write_coef(3'd5, 32'h7FFF_FFFF);
    write_coef(3'd7, 32'h8000_0000);

    // R2 / R3 / R7: table walk, each result depends on shifted history
    for (int i = 0; i < 10; i++)
      run_sample(STIM[i], "R2 R3 R7 table output", (i == 3) ? 3 : 0);

    // R8: write b0 right after acceptance; old b0 must still be used
    exp = model_y(32'h4000_0000);
    push(32'h4000_0000);
    coef_we = 1'b1; coef_sel = 3'd0; coef_wdata = 32'h7FFF_FFFF;
    @(negedge clk);
    coef_we = 1'b0;
    wait_out(lat);
    chk(out_data == exp, "R8 write during compute", out_data, exp);
    take_out();
    model_shift(32'h4000_0000, exp);
    run_sample(32'h1000_0000, "R8 coefficient unchanged", 0);

    // R9: clear in idle
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    model_clear();
    run_sample(32'h4000_0000, "R9 history cleared", 0);

    // R9: clear during multiply steps aborts the sample
    push(32'h3000_0000);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    model_clear();
    chk(in_ready == 1'b1, "R9 idle after clear", 32'(in_ready), 32'd1);
    repeat (6) @(negedge clk);
    chk(out_valid == 1'b0, "R9 sample discarded", 32'(out_valid), 32'd0);
    run_sample(32'h5000_0000, "R9 zero history after abort", 0);

    // R10: full negative taps and samples overflow the accumulator
    write_coef(3'd0, 32'h8000_0000);
    write_coef(3'd1, 32'h8000_0000);
    write_coef(3'd2, 32'h8000_0000);
    write_coef(3'd3, 32'h0000_0000);
    write_coef(3'd4, 32'h0000_0000);
    model_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    for (int i = 0; i < 3; i++)
      run_sample(32'h8000_0000, "R10 wrap not saturate", 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule